// File: doc/BRIEF.md
# Sequential Shift-Add Integer Multiplier

This block multiplies two `W`-bit integers over `W` clock cycles with a single adder. A one-cycle start request captures the multiplicand, the multiplier and a sign-mode select. On each following cycle the block examines one multiplier bit, starting with the least significant. It adds the multiplicand into the upper half of a partial product register, or adds nothing, and shifts the whole register right by one place in the same clock. The shift is built into the load wiring, so no separate shift cycle is needed. The lower half of that register starts out holding the multiplier. Product bits enter it from the top while multiplier bits leave from the bottom.

In unsigned mode the carry out of the add becomes the new top bit. In two's-complement mode the partial sum is sign-extended by one bit. On the last step, which handles the multiplier's sign bit, the multiplicand is subtracted instead of added. The `2W`-bit product is given as a high word and a low word. A flag reports whether the product can be represented in a single `W`-bit word under the selected mode. The caller pulses start while the block is idle, waits for the one-cycle done pulse, and then reads the words. The words stay unchanged until the next accepted start.

Top module: `shift_add_multiplier`

## Requirements
- R1: With `signed_mode` = 0, `{prod_hi, prod_lo}` equals the unsigned product of the two captured operands once `done` is seen.
- R2: With `signed_mode` = 1, `{prod_hi, prod_lo}` equals the two's-complement product of the two captured operands, as a `2W`-bit signed value, once `done` is seen.
- R3: When `done` is seen, `fits_word` is 1 exactly when the product lies in the mode's `W`-bit range. That range is 0 to 2^W-1 for unsigned and -2^(W-1) to 2^(W-1)-1 for signed. In unsigned mode this means `prod_hi` is zero. In signed mode it means every bit of `prod_hi` equals bit `W-1` of `prod_lo`.
- R4: After a start is accepted, `busy` is high for exactly `W` cycles. `done` is high for exactly one cycle, the cycle in which `busy` falls.
- R5: A start sampled while `busy` is high is ignored, and so are any new operand or mode values. The running operation finishes with its own result and its own timing. A start sampled while idle makes `busy` high on the next cycle.
- R6: While the block is idle and no start is sampled, `prod_hi`, `prod_lo` and `fits_word` keep their values.
- R7: While `rst_n` is low, and after it is released, the block has `busy` = 0, `done` = 0, `prod_hi` = 0 and `prod_lo` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Start request, accepted only while idle |
| signed_mode | input | 1 | 0 = unsigned, 1 = two's complement; captured at start |
| multiplicand | input | W | Multiplicand operand |
| multiplier | input | W | Multiplier operand |
| busy | output | 1 | High while an operation is stepping |
| done | output | 1 | One-cycle pulse when the product is ready |
| prod_hi | output | W | Upper word of the product |
| prod_lo | output | W | Lower word of the product |
| fits_word | output | 1 | Product fits in one W-bit word under the captured mode |

## Verification
Every pair drawn from a set of boundary operands is run in both modes. The set is zero, one, two, all ones, the most negative value, the most positive signed value and two alternating bit patterns. These pairs separate a missing carry-out (unsigned all-ones squared) from a missing final subtraction (any negative multiplier) and from a wrong sign extension (negative multiplicand with a positive multiplier). The most-negative-squared case and the most-negative times minus-one case sit at the edge of the fit flag. Several thousand pseudo-random pairs in both modes cover the general add and shift path. A further operation is disturbed mid-run by a second start that carries other operands and the opposite mode, to show that captured state is not overwritten. An idle stretch after a result shows that the output words hold.

// File: rtl/mul_pkg.sv
// Package: shared types for the shift-add multiplier.
// Assumes: nothing beyond standard SystemVerilog.
package mul_pkg;

    // Arithmetic interpretation of the operands
    typedef enum logic {
        MODE_UNSIGNED = 1'b0,
        MODE_SIGNED   = 1'b1
    } mul_mode_e;

endpackage

// File: rtl/mul_step_ctrl.sv
// Module: mul_step_ctrl
// Counts the W stepping cycles of one multiplication. It raises busy for
// exactly W cycles after an accepted start and pulses done as busy falls.
// Assumes: W >= 2; start is sampled on every clock and ignored while busy.
module mul_step_ctrl #(
    parameter int W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic accept,
    output logic busy,
    output logic last_step,
    output logic done
);
    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] LAST_IDX = CW'(W - 1);

    logic [CW-1:0] step_q;

    // A start takes effect only while idle
    always_comb accept = start && !busy;

    // The step that consumes the multiplier's top bit
    always_comb last_step = busy && (step_q == LAST_IDX);

    // Step counter, busy and done sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            step_q <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                busy   <= 1'b1;
                step_q <= '0;
            end else if (busy) begin
                if (step_q == LAST_IDX) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    step_q <= step_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mul_pp_datapath.sv
// Module: mul_pp_datapath
// Holds the partial product. The upper half accumulates and the lower half
// starts as the multiplier. Each step performs one add (or subtract on the
// final signed step) with the right shift wired into the register load.
// Assumes: load and step are never high together (control guarantees it).
module mul_pp_datapath
    import mul_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic         last_step,
    input  mul_mode_e    mode_in,
    input  logic [W-1:0] mcand_in,
    input  logic [W-1:0] mplier_in,
    output mul_mode_e    mode_q,
    output logic [W-1:0] hi_q,
    output logic [W-1:0] lo_q
);
    localparam int XW = W + 1;

    logic [W-1:0]  mcand_q;
    logic [XW-1:0] hi_ext;
    logic [XW-1:0] mcand_ext;
    logic [XW-1:0] addend;
    logic [XW-1:0] sum;
    logic          is_signed;

    always_comb is_signed = (mode_q == MODE_SIGNED);

    // Widen both operands by one bit: sign copy when signed, zero otherwise
    always_comb begin
        hi_ext    = {is_signed & hi_q[W-1], hi_q};
        mcand_ext = {is_signed & mcand_q[W-1], mcand_q};
    end

    // Select the addend from the current multiplier bit; negate on the signed final step
    always_comb begin
        if (!lo_q[0])
            addend = '0;
        else if (is_signed && last_step)
            addend = ~mcand_ext + 1'b1;
        else
            addend = mcand_ext;
        sum = hi_ext + addend;
    end

    // Capture operands on accept; on each step load the sum already shifted right
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= MODE_UNSIGNED;
            mcand_q <= '0;
            hi_q    <= '0;
            lo_q    <= '0;
        end else if (load) begin
            mode_q  <= mode_in;
            mcand_q <= mcand_in;
            hi_q    <= '0;
            lo_q    <= mplier_in;
        end else if (step) begin
            hi_q <= sum[XW-1:1];
            lo_q <= {sum[0], lo_q[W-1:1]};
        end
    end
endmodule

// File: rtl/mul_fit_detect.sv
// Module: mul_fit_detect
// Decides from the two product words whether the product fits one word.
// Assumes: the words hold a complete product (only meaningful after done).
module mul_fit_detect
    import mul_pkg::*;
#(
    parameter int W = 8
) (
    input  mul_mode_e    mode,
    input  logic [W-1:0] hi,
    input  logic [W-1:0] lo,
    output logic         fits
);
    // Unsigned: upper word empty; signed: upper word is pure sign copy of lower word
    always_comb begin
        if (mode == MODE_SIGNED)
            fits = (hi == {W{lo[W-1]}});
        else
            fits = (hi == '0);
    end
endmodule

// File: rtl/shift_add_multiplier.sv
// Module: shift_add_multiplier (top)
// W-cycle radix-2 multiplier with start/busy/done handshake, split product
// words and a fits-in-one-word flag.
// Assumes: W >= 2; the caller reads the product on or after the done pulse.
module shift_add_multiplier
    import mul_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         signed_mode,
    input  logic [W-1:0] multiplicand,
    input  logic [W-1:0] multiplier,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] prod_hi,
    output logic [W-1:0] prod_lo,
    output logic         fits_word
);
    logic      accept;
    logic      last_step;
    mul_mode_e mode_in;
    mul_mode_e mode_q;

    // Map the raw mode pin onto the package type
    always_comb mode_in = signed_mode ? MODE_SIGNED : MODE_UNSIGNED;

    mul_step_ctrl #(.W(W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .accept    (accept),
        .busy      (busy),
        .last_step (last_step),
        .done      (done)
    );

    mul_pp_datapath #(.W(W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .step      (busy),
        .last_step (last_step),
        .mode_in   (mode_in),
        .mcand_in  (multiplicand),
        .mplier_in (multiplier),
        .mode_q    (mode_q),
        .hi_q      (prod_hi),
        .lo_q      (prod_lo)
    );

    mul_fit_detect #(.W(W)) u_fit (
        .mode (mode_q),
        .hi   (prod_hi),
        .lo   (prod_lo),
        .fits (fits_word)
    );
endmodule

// File: rtl/shift_add_multiplier_checks.sv
// Module: shift_add_multiplier_checks
// Protocol properties of the multiplier, observed on its ports and bound
// into every instance of the top module.
// Assumes: synchronous active-low reset held for at least one clock.
module shift_add_multiplier_checks #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] prod_hi,
    input logic [W-1:0] prod_lo
);
    logic [31:0] busy_run;

    // Independent count of consecutive busy cycles
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy_run <= '0;
        else if (busy)
            busy_run <= busy_run + 1'b1;
        else
            busy_run <= '0;
    end

    // R4: busy lasts exactly W cycles
    p_busy_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_run == 32'(W)));

    // R4: done coincides with the fall of busy
    p_done_at_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $fell(busy));

    // R4: done is a single-cycle pulse
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: an idle start begins an operation
    p_idle_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R6: results hold while idle without a start
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(prod_hi) && $stable(prod_lo)));

    // R7: reset clears the handshake and the words
    p_reset_r7: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && prod_hi == '0 && prod_lo == '0));
endmodule

bind shift_add_multiplier shift_add_multiplier_checks #(.W(W)) u_checks (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .prod_hi (prod_hi),
    .prod_lo (prod_lo)
);

// File: tb/shift_add_multiplier_tb.sv
module shift_add_multiplier_tb;
    localparam int W = 8;
    localparam int WATCHDOG = 150000;

    typedef struct packed {
        logic [2*W-1:0] prod;
        logic           fit;
        logic           mode;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         signed_mode = 1'b0;
    logic [W-1:0] multiplicand = '0;
    logic [W-1:0] multiplier = '0;
    logic         busy;
    logic         done;
    logic [W-1:0] prod_hi;
    logic [W-1:0] prod_lo;
    logic         fits_word;

    int   checks = 0;
    int   errors = 0;
    int   cycles = 0;
    int   busy_cnt = 0;
    logic prev_done = 1'b0;
    exp_t sb_q[$];
    exp_t last_exp;
    logic [15:0] lfsr = 16'hACE1;

    shift_add_multiplier #(.W(W)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .signed_mode  (signed_mode),
        .multiplicand (multiplicand),
        .multiplier   (multiplier),
        .busy         (busy),
        .done         (done),
        .prod_hi      (prod_hi),
        .prod_lo      (prod_lo),
        .fits_word    (fits_word)
    );

    always #5 clk = ~clk;

    function automatic int as_int(input logic [W-1:0] v, input logic sgn);
        if (sgn && v[W-1]) return int'(v) - (1 << W);
        return int'(v);
    endfunction

    // Behavioural reference for product and fit flag
    function automatic exp_t reference(input logic [W-1:0] a, input logic [W-1:0] b,
                                       input logic sgn);
        exp_t e;
        int   p;
        p      = as_int(a, sgn) * as_int(b, sgn);
        e.prod = (2*W)'(p);
        e.mode = sgn;
        if (sgn) e.fit = (p >= -(1 << (W-1))) && (p < (1 << (W-1)));
        else     e.fit = (p < (1 << W));
        return e;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Driver: start one operation and push its expected result
    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic sgn);
        multiplicand = a;
        multiplier   = b;
        signed_mode  = sgn;
        start        = 1'b1;
        sb_q.push_back(reference(a, b, sgn));
        @(negedge clk);
        start = 1'b0;
        while (busy) @(negedge clk);
    endtask

    // Driver: as run_op, but a second start with other inputs arrives mid-run (R5)
    task automatic run_op_disturbed(input logic [W-1:0] a, input logic [W-1:0] b,
                                    input logic sgn);
        multiplicand = a;
        multiplier   = b;
        signed_mode  = sgn;
        start        = 1'b1;
        sb_q.push_back(reference(a, b, sgn));
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        multiplicand = ~a;
        multiplier   = b ^ 8'h5A;
        signed_mode  = ~sgn;
        start        = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (busy) @(negedge clk);
    endtask

    // Monitor: pop and compare on each done, and time the busy window
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) busy_cnt++;
            if (done) begin
                check(!prev_done, "R4", "done longer than one cycle", 1, 0);
                check(busy_cnt == W, "R4", "busy cycles before done", busy_cnt, W);
                busy_cnt = 0;
                if (sb_q.size() == 0) begin
                    check(1'b0, "R4", "done without pending operation", 1, 0);
                end else begin
                    last_exp = sb_q.pop_front();
                    check({prod_hi, prod_lo} == last_exp.prod,
                          last_exp.mode ? "R2" : "R1", "product",
                          {prod_hi, prod_lo}, last_exp.prod);
                    check(fits_word == last_exp.fit, "R3", "fits_word",
                          fits_word, last_exp.fit);
                end
            end
            prev_done = done;
        end
    end

    // Watchdog: a hung run counts as a failure
    always @(posedge clk) begin
        cycles++;
        if (cycles >= WATCHDOG) begin
            check(1'b0, "R4", "watchdog expired", cycles, WATCHDOG);
            finish_run();
        end
    end

    initial begin
        logic [W-1:0] corners [8];
        corners[0] = '0;
        corners[1] = W'(1);
        corners[2] = W'(2);
        corners[3] = '1;
        corners[4] = W'(1) << (W-1);
        corners[5] = ~(W'(1) << (W-1));
        corners[6] = {(W/2){2'b01}};
        corners[7] = {(W/2){2'b10}};

        repeat (3) @(negedge clk);
        // R7: state during reset
        check(!busy && !done, "R7", "handshake in reset", {busy, done}, 0);
        check(prod_hi == '0 && prod_lo == '0, "R7", "words in reset",
              {prod_hi, prod_lo}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && prod_hi == '0 && prod_lo == '0, "R7",
              "state after reset", {busy, done, prod_hi, prod_lo}, 0);

        // R1 R2 R3: every boundary pair in both modes
        for (int m = 0; m < 2; m++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    run_op(corners[i], corners[j], m[0]);

        // R1 R2: pseudo-random pairs
        for (int n = 0; n < 3000; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            run_op(lfsr[W-1:0], lfsr[15:16-W] ^ W'(n), n[0]);
        end

        // R5: second start, operands and mode ignored while busy
        run_op_disturbed(8'hF3, 8'h9D, 1'b1);
        run_op_disturbed(8'hC8, 8'hB7, 1'b0);

        // R6: words hold through an idle stretch after done
        @(negedge clk);
        repeat (6) @(negedge clk);
        check({prod_hi, prod_lo} == last_exp.prod, "R6", "product held while idle",
              {prod_hi, prod_lo}, last_exp.prod);
        check(fits_word == last_exp.fit, "R6", "fit flag held while idle",
              fits_word, last_exp.fit);
        check(!busy && !done, "R6", "stays idle without start", {busy, done}, 0);

        check(sb_q.size() == 0, "R4", "results outstanding at end", sb_q.size(), 0);
        finish_run();
    end
endmodule